// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block performs the byte arithmetic of a classic 8-bit accumulator machine. It produces the next value of the status word, which holds the carry (C), auxiliary carry (AC) and overflow (OV) flags. Each cycle it can take one operation: an operation code, the accumulator byte and a second operand byte. One clock later it presents the result byte and, for multiply and divide, a second result byte. It also presents the updated status word.

Each operation has its own rule for the three flags. Some operations write a flag, some force it to a value, and some leave it alone. The status word can also be written by software, either as a whole byte at its register address or one bit at a time through its bit addresses. A direct write issued in the same cycle as an operation wins on the bits that it writes. The status word is held inside the block, so every operation reads the current C and AC from it.

Top module: `alu_flag_core`

## Requirements
- R1: After reset, `res_a`, `res_b` and `stat_q` are all zero.
- R2: Operation codes 0 (add) and 1 (add with carry) are handled as follows. `res_a` becomes acc+opnd, plus C for code 1 only. C is set to the carry out of bit 7. AC is set to the carry out of bit 3. OV is set to the carry into bit 7 XOR the carry out of bit 7. All results appear one clock after `op_valid`.
- R3: Operation code 2 (subtract with borrow) sets `res_a` to acc-opnd-C. C is set to the borrow out of bit 7. AC is set to the borrow into bit 4 from the low nibble. OV is set when the signed result is outside -128..127.
- R4: Operation code 3 (multiply) puts the low byte of the 16-bit product on `res_a` and the high byte on `res_b`. It sets OV when the product exceeds 255, clears C and leaves AC unchanged.
- R5: Operation code 4 (divide) handles a nonzero divisor by putting the quotient on `res_a` and the remainder on `res_b`, then clearing OV. A zero divisor sets OV and leaves both result bytes undefined. In both cases C is cleared and AC is unchanged.
- R6: Operation code 5 (decimal adjust) works in two steps. It adds 6 when the low nibble is above 9 or AC is set. It then adds 0x60 when the high nibble of that sum is above 9 or C is set. A carry out of either step sets C, and a C that is already set stays set. OV and AC are unchanged.
- R7: Operation code 6 rotates acc right through C, and operation code 7 rotates it left through C. Only C changes among the flags.
- R8: Operation code 8 (compare) sets C when acc < opnd, compared unsigned. `res_a` repeats acc, and OV and AC are unchanged.
- R9: A byte write (`sfr_wr_en`) to address `PSW_ADDR` (0xD0) loads the whole status word. C is bit 7, AC is bit 6 and OV is bit 2. A byte write to any other address has no effect.
- R10: A bit write (`bit_wr_en`) to address `PSW_ADDR`+n, for n from 1 to 7, sets status bit n to `bit_wdata`. Bit addresses `PSW_ADDR` and `PSW_ADDR`+8 have no effect.
- R11: A direct write in the same cycle as an operation overrides the flag the operation would set, but only on the bits it writes. Codes 9 to 15 change nothing. `res_b` changes only for codes 3 and 4, and the status word holds when nothing is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue the operation this cycle |
| op_sel | input | 4 | Operation code (see R2-R8, R11) |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand or divisor |
| sfr_wr_en | input | 1 | Byte register write strobe |
| sfr_addr | input | 8 | Byte register address |
| sfr_wdata | input | 8 | Byte register write data |
| bit_wr_en | input | 1 | Bit write strobe |
| bit_addr | input | 8 | Bit address |
| bit_wdata | input | 1 | Bit write value |
| res_a | output | 8 | Registered accumulator result |
| res_b | output | 8 | Registered second result (product high byte or remainder) |
| stat_q | output | 8 | Registered status word |

## Verification
The bench builds the block with the default `PSW_ADDR` of 0xD0. It places bit writes at 0xD0 and 0xD8, one address outside each end of the live bit window, and at 0xD1, just inside it, so both edges of the window decode are exercised. Byte writes are aimed at 0xD1 as well as at the real register address. Because the address is fixed, the bench can pin every status bit position. Other bits of the status word are preloaded before each operation, which shows that an operation changes only the flags its rule allows.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int BYTE_W = 8;
  localparam int C_POS  = 7;
  localparam int AC_POS = 6;
  localparam int OV_POS = 2;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUBB = 4'd2,
    OP_MUL  = 4'd3,
    OP_DIV  = 4'd4,
    OP_DA   = 4'd5,
    OP_RRC  = 4'd6,
    OP_RLC  = 4'd7,
    OP_CJNE = 4'd8
  } op_e;

  typedef struct packed {
    logic [BYTE_W-1:0] a;
    logic [BYTE_W-1:0] b;
    logic              c;
    logic              ov;
    logic              ac;
  } alu_out_t;

  typedef struct packed {
    logic c;
    logic ov;
    logic ac;
    logic ra;
    logic rb;
  } wr_mask_t;

  function automatic alu_out_t add_fn(input logic [7:0] a, input logic [7:0] b, input logic cin);
    alu_out_t o;
    logic [8:0] s;
    logic [4:0] lo;
    logic [7:0] lo7;
    o   = '0;
    s   = {1'b0, a} + {1'b0, b} + {8'd0, cin};
    lo  = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, cin};
    lo7 = {1'b0, a[6:0]} + {1'b0, b[6:0]} + {7'd0, cin};
    o.a  = s[7:0];
    o.c  = s[8];
    o.ac = lo[4];
    o.ov = lo7[7] ^ s[8];
    return o;
  endfunction

  function automatic alu_out_t sub_fn(input logic [7:0] a, input logic [7:0] b, input logic cin);
    alu_out_t o;
    logic [8:0] s;
    logic [4:0] lo;
    logic [7:0] lo7;
    o   = '0;
    s   = {1'b0, a} - {1'b0, b} - {8'd0, cin};
    lo  = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'd0, cin};
    lo7 = {1'b0, a[6:0]} - {1'b0, b[6:0]} - {7'd0, cin};
    o.a  = s[7:0];
    o.c  = s[8];
    o.ac = lo[4];
    o.ov = lo7[7] ^ s[8];
    return o;
  endfunction

  function automatic alu_out_t mul_fn(input logic [7:0] a, input logic [7:0] b);
    alu_out_t o;
    logic [15:0] p;
    o    = '0;
    p    = {8'd0, a} * {8'd0, b};
    o.a  = p[7:0];
    o.b  = p[15:8];
    o.ov = |p[15:8];
    return o;
  endfunction

  function automatic alu_out_t div_fn(input logic [7:0] a, input logic [7:0] b);
    alu_out_t o;
    o = '0;
    if (b == 8'd0) begin
      o.a  = a;
      o.b  = b;
      o.ov = 1'b1;
    end else begin
      o.a = a / b;
      o.b = a % b;
    end
    return o;
  endfunction

  function automatic alu_out_t da_fn(input logic [7:0] a, input logic cin, input logic acin);
    alu_out_t o;
    logic [8:0] t;
    logic       cc;
    o  = '0;
    t  = {1'b0, a};
    cc = cin;
    if (a[3:0] > 4'd9 || acin) t = t + 9'd6;
    cc   = cc | t[8];
    t[8] = 1'b0;
    if (t[7:4] > 4'd9 || cc) t = t + 9'h060;
    cc  = cc | t[8];
    o.a = t[7:0];
    o.c = cc;
    return o;
  endfunction
endpackage

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
  import alu_flag_pkg::*;
(
  input  logic [3:0]        op,
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  input  logic              c_in,
  input  logic              ac_in,
  output alu_out_t          res,
  output wr_mask_t          mask
);
  always_comb begin
    res  = '0;
    mask = '0;
    case (op)
      OP_ADD: begin
        res  = add_fn(a, b, 1'b0);
        mask = '{c: 1'b1, ov: 1'b1, ac: 1'b1, ra: 1'b1, rb: 1'b0};
      end
      OP_ADDC: begin
        res  = add_fn(a, b, c_in);
        mask = '{c: 1'b1, ov: 1'b1, ac: 1'b1, ra: 1'b1, rb: 1'b0};
      end
      OP_SUBB: begin
        res  = sub_fn(a, b, c_in);
        mask = '{c: 1'b1, ov: 1'b1, ac: 1'b1, ra: 1'b1, rb: 1'b0};
      end
      OP_MUL: begin
        res  = mul_fn(a, b);
        mask = '{c: 1'b1, ov: 1'b1, ac: 1'b0, ra: 1'b1, rb: 1'b1};
      end
      OP_DIV: begin
        res  = div_fn(a, b);
        mask = '{c: 1'b1, ov: 1'b1, ac: 1'b0, ra: 1'b1, rb: 1'b1};
      end
      OP_DA: begin
        res  = da_fn(a, c_in, ac_in);
        mask = '{c: 1'b1, ov: 1'b0, ac: 1'b0, ra: 1'b1, rb: 1'b0};
      end
      OP_RRC: begin
        res.a = {c_in, a[7:1]};
        res.c = a[0];
        mask  = '{c: 1'b1, ov: 1'b0, ac: 1'b0, ra: 1'b1, rb: 1'b0};
      end
      OP_RLC: begin
        res.a = {a[6:0], c_in};
        res.c = a[7];
        mask  = '{c: 1'b1, ov: 1'b0, ac: 1'b0, ra: 1'b1, rb: 1'b0};
      end
      OP_CJNE: begin
        res.a = a;
        res.c = (a < b);
        mask  = '{c: 1'b1, ov: 1'b0, ac: 1'b0, ra: 1'b1, rb: 1'b0};
      end
      default: begin
        res  = '0;
        mask = '0;
      end
    endcase
  end

  // R6: decimal adjust must never report a cleared carry when carry came in set
  always_comb begin
    a_r6_da_sticky_c: assert (!(op == OP_DA && c_in && !res.c));
  end
endmodule

// File: rtl/psw_wr_decode.sv
module psw_wr_decode #(
  parameter logic [7:0] PSW_ADDR = 8'hD0
) (
  input  logic       sfr_wr_en,
  input  logic [7:0] sfr_addr,
  input  logic       bit_wr_en,
  input  logic [7:0] bit_addr,
  output logic       byte_hit,
  output logic       bit_hit,
  output logic [2:0] bit_idx
);
  logic [7:0] off;

  always_comb begin
    off      = bit_addr - PSW_ADDR;
    byte_hit = sfr_wr_en && (sfr_addr == PSW_ADDR);
    // live bit window: PSW_ADDR+1 .. PSW_ADDR+7
    bit_hit  = bit_wr_en && (off[7:3] == 5'd0) && (off[2:0] != 3'd0);
    bit_idx  = off[2:0];
  end

  // R10: a bit hit never points at bit 0
  always_comb begin
    a_r10_no_bit0: assert (!(bit_hit && bit_idx == 3'd0));
  end
endmodule

// File: rtl/psw_reg.sv
module psw_reg
  import alu_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  wr_mask_t          mask,
  input  logic              nxt_c,
  input  logic              nxt_ov,
  input  logic              nxt_ac,
  input  logic              byte_we,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              bit_we,
  input  logic [2:0]        bit_idx,
  input  logic              bit_val,
  output logic [BYTE_W-1:0] psw_q
);
  logic [BYTE_W-1:0] op_next;
  logic [BYTE_W-1:0] psw_d;

  always_comb begin
    op_next = psw_q;
    if (upd_en) begin
      if (mask.c)  op_next[C_POS]  = nxt_c;
      if (mask.ov) op_next[OV_POS] = nxt_ov;
      if (mask.ac) op_next[AC_POS] = nxt_ac;
    end
    psw_d = op_next;
    if (byte_we) psw_d = byte_data;
    if (bit_we)  psw_d[bit_idx] = bit_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) psw_q <= '0;
    else        psw_q <= psw_d;
  end

  a_r9_byte_load: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we && !bit_we |=> psw_q == $past(byte_data));

  a_r10_bit_load: assert property (@(posedge clk) disable iff (!rst_n)
    bit_we |=> psw_q[$past(bit_idx)] == $past(bit_val));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en && !byte_we && !bit_we |=> $stable(psw_q));
endmodule

// File: rtl/alu_flag_core.sv
module alu_flag_core
  import alu_flag_pkg::*;
#(
  parameter logic [7:0] PSW_ADDR = 8'hD0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [3:0] op_sel,
  input  logic [7:0] acc_in,
  input  logic [7:0] opnd_in,
  input  logic       sfr_wr_en,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  input  logic       bit_wr_en,
  input  logic [7:0] bit_addr,
  input  logic       bit_wdata,
  output logic [7:0] res_a,
  output logic [7:0] res_b,
  output logic [7:0] stat_q
);
  alu_out_t   alu_res;
  wr_mask_t   alu_mask;
  logic       op_known;
  logic       upd_en;
  logic       byte_hit;
  logic       bit_hit;
  logic [2:0] bit_idx;
  logic       any_wr;

  assign op_known = (op_sel <= OP_CJNE);
  assign upd_en   = op_valid && op_known;
  assign any_wr   = byte_hit || bit_hit;

  alu_arith_unit u_arith (
    .op    (op_sel),
    .a     (acc_in),
    .b     (opnd_in),
    .c_in  (stat_q[C_POS]),
    .ac_in (stat_q[AC_POS]),
    .res   (alu_res),
    .mask  (alu_mask)
  );

  psw_wr_decode #(.PSW_ADDR(PSW_ADDR)) u_dec (
    .sfr_wr_en (sfr_wr_en),
    .sfr_addr  (sfr_addr),
    .bit_wr_en (bit_wr_en),
    .bit_addr  (bit_addr),
    .byte_hit  (byte_hit),
    .bit_hit   (bit_hit),
    .bit_idx   (bit_idx)
  );

  psw_reg u_psw (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (upd_en),
    .mask      (alu_mask),
    .nxt_c     (alu_res.c),
    .nxt_ov    (alu_res.ov),
    .nxt_ac    (alu_res.ac),
    .byte_we   (byte_hit),
    .byte_data (sfr_wdata),
    .bit_we    (bit_hit),
    .bit_idx   (bit_idx),
    .bit_val   (bit_wdata),
    .psw_q     (stat_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_a <= '0;
      res_b <= '0;
    end else if (upd_en) begin
      if (alu_mask.ra) res_a <= alu_res.a;
      if (alu_mask.rb) res_b <= alu_res.b;
    end
  end

  // R4/R5: multiply and divide leave carry cleared
  a_r4_muldiv_clear_c: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_sel == OP_MUL || op_sel == OP_DIV) && !any_wr |=> !stat_q[C_POS]);

  a_r7_c_only: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_sel == OP_DA || op_sel == OP_RRC || op_sel == OP_RLC || op_sel == OP_CJNE)
    && !any_wr |=> stat_q[OV_POS] == $past(stat_q[OV_POS]) && stat_q[AC_POS] == $past(stat_q[AC_POS]));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid && !any_wr |=> $stable(stat_q) && $stable(res_a) && $stable(res_b));

  a_r11_resb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && (op_sel == OP_MUL || op_sel == OP_DIV)) |=> $stable(res_b));
endmodule

// File: tb/sim_alu_flag_core.sv
module sim_alu_flag_core;
  import alu_flag_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_sel = '0;
  logic [7:0] acc_in = '0;
  logic [7:0] opnd_in = '0;
  logic       sfr_wr_en = 1'b0;
  logic [7:0] sfr_addr = '0;
  logic [7:0] sfr_wdata = '0;
  logic       bit_wr_en = 1'b0;
  logic [7:0] bit_addr = '0;
  logic       bit_wdata = 1'b0;
  logic [7:0] res_a, res_b, stat_q;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] exp_psw = '0;

  always #5 clk = ~clk;

  alu_flag_core u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .acc_in(acc_in), .opnd_in(opnd_in), .sfr_wr_en(sfr_wr_en),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .bit_wr_en(bit_wr_en),
    .bit_addr(bit_addr), .bit_wdata(bit_wdata), .res_a(res_a),
    .res_b(res_b), .stat_q(stat_q)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic logic [7:0] with_flags(input logic [7:0] p, input int c, input int ov, input int ac);
    logic [7:0] r;
    r = p;
    if (c  >= 0) r[7] = (c != 0);
    if (ac >= 0) r[6] = (ac != 0);
    if (ov >= 0) r[2] = (ov != 0);
    return r;
  endfunction

  task automatic set_psw(input logic [7:0] v);
    sfr_wr_en = 1'b1; sfr_addr = 8'hD0; sfr_wdata = v;
    @(negedge clk);
    sfr_wr_en = 1'b0;
    exp_psw = v;
  endtask

  task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    op_valid = 1'b1; op_sel = op; acc_in = a; opnd_in = b;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 res_a", res_a, 8'h00);
    chk("R1 res_b", res_b, 8'h00);
    chk("R1 status", stat_q, 8'h00);
  endtask

  // kind 0 add, 1 add with carry, 2 subtract with borrow
  task automatic t_arith(input int kind, input logic [7:0] a, input logic [7:0] b, input logic [7:0] start);
    int ci, s, ec, eac, eov, sv;
    string tag;
    set_psw(start);
    ci = (kind == 0) ? 0 : int'(start[7]);
    if (kind < 2) begin
      s   = int'(a) + int'(b) + ci;
      ec  = (s > 255) ? 1 : 0;
      eac = ((int'(a) % 16) + (int'(b) % 16) + ci > 15) ? 1 : 0;
      sv  = sgn(int'(a)) + sgn(int'(b)) + ci;
      tag = "R2";
    end else begin
      s   = int'(a) - int'(b) - ci;
      ec  = (s < 0) ? 1 : 0;
      eac = ((int'(a) % 16) < (int'(b) % 16) + ci) ? 1 : 0;
      sv  = sgn(int'(a)) - sgn(int'(b)) - ci;
      tag = "R3";
    end
    eov = (sv > 127 || sv < -128) ? 1 : 0;
    run_op(kind == 0 ? OP_ADD : (kind == 1 ? OP_ADDC : OP_SUBB), a, b);
    exp_psw = with_flags(exp_psw, ec, eov, eac);
    chk({tag, " result"}, res_a, 8'((s + 512) % 256));
    chk({tag, " status"}, stat_q, exp_psw);
  endtask

  task automatic t_mul(input logic [7:0] a, input logic [7:0] b);
    int p;
    set_psw(8'hC4);
    p = int'(a) * int'(b);
    run_op(OP_MUL, a, b);
    exp_psw = with_flags(exp_psw, 0, (p > 255) ? 1 : 0, -1);
    chk("R4 low", res_a, 8'(p % 256));
    chk("R4 high", res_b, 8'(p / 256));
    chk("R4 status", stat_q, exp_psw);
  endtask

  task automatic t_div(input logic [7:0] a, input logic [7:0] b);
    set_psw(8'hC0);
    run_op(OP_DIV, a, b);
    if (b == 8'd0) begin
      exp_psw = with_flags(exp_psw, 0, 1, -1);
      chk("R5 zero-divisor status", stat_q, exp_psw);
    end else begin
      exp_psw = with_flags(exp_psw, 0, 0, -1);
      chk("R5 quotient", res_a, 8'(int'(a) / int'(b)));
      chk("R5 remainder", res_b, 8'(int'(a) % int'(b)));
      chk("R5 status", stat_q, exp_psw);
    end
  endtask

  task automatic t_da(input logic [7:0] a, input logic [7:0] start);
    int v, cc;
    set_psw(start);
    v  = int'(a);
    cc = int'(start[7]);
    if ((v % 16) > 9 || start[6]) v = v + 6;
    if (v > 255) cc = 1;
    v = v % 256;
    if ((v / 16) > 9 || cc != 0) v = v + 96;
    if (v > 255) cc = 1;
    run_op(OP_DA, a, 8'h00);
    exp_psw = with_flags(exp_psw, cc, -1, -1);
    chk("R6 result", res_a, 8'(v % 256));
    chk("R6 status", stat_q, exp_psw);
  endtask

  task automatic t_rot(input bit left, input logic [7:0] a, input logic [7:0] start);
    int v;
    set_psw(start);
    if (left) v = (int'(a) * 2) % 256 + int'(start[7]);
    else      v = int'(a) / 2 + 128 * int'(start[7]);
    run_op(left ? OP_RLC : OP_RRC, a, 8'h00);
    exp_psw = with_flags(exp_psw, left ? int'(a[7]) : int'(a[0]), -1, -1);
    chk("R7 result", res_a, 8'(v));
    chk("R7 status", stat_q, exp_psw);
  endtask

  task automatic t_cmp(input logic [7:0] a, input logic [7:0] b, input logic [7:0] start);
    set_psw(start);
    run_op(OP_CJNE, a, b);
    exp_psw = with_flags(exp_psw, (int'(a) < int'(b)) ? 1 : 0, -1, -1);
    chk("R8 result", res_a, a);
    chk("R8 status", stat_q, exp_psw);
  endtask

  task automatic bit_wr(input logic [7:0] addr, input logic v);
    bit_wr_en = 1'b1; bit_addr = addr; bit_wdata = v;
    @(negedge clk);
    bit_wr_en = 1'b0;
  endtask

  task automatic t_psw_writes();
    set_psw(8'h5A);
    chk("R9 byte load", stat_q, 8'h5A);
    sfr_wr_en = 1'b1; sfr_addr = 8'hD1; sfr_wdata = 8'hFF;
    @(negedge clk);
    sfr_wr_en = 1'b0;
    chk("R9 other byte address ignored", stat_q, 8'h5A);
    bit_wr(8'hD7, 1'b1);
    chk("R10 bit 7 set", stat_q, 8'hDA);
    bit_wr(8'hD2, 1'b1);
    chk("R10 bit 2 set", stat_q, 8'hDE);
    bit_wr(8'hD1, 1'b0);
    chk("R10 bit 1 cleared", stat_q, 8'hDC);
    bit_wr(8'hD0, 1'b1);
    chk("R10 bit address D0 ignored", stat_q, 8'hDC);
    bit_wr(8'hD8, 1'b1);
    chk("R10 bit address D8 ignored", stat_q, 8'hDC);
    exp_psw = 8'hDC;
  endtask

  task automatic t_priority();
    logic [7:0] prev_b;
    set_psw(8'h00);
    run_op(OP_MUL, 8'h20, 8'h10);
    prev_b = res_b;
    // add FF+01 gives C=1, AC=1, OV=0; a same-cycle bit write clears C
    op_valid = 1'b1; op_sel = OP_ADD; acc_in = 8'hFF; opnd_in = 8'h01;
    bit_wr_en = 1'b1; bit_addr = 8'hD7; bit_wdata = 1'b0;
    @(negedge clk);
    op_valid = 1'b0; bit_wr_en = 1'b0;
    chk("R11 write overrides C only", stat_q, 8'h40);
    chk("R11 res_b held by add", res_b, prev_b);
    op_valid = 1'b1; op_sel = 4'hF; acc_in = 8'h77; opnd_in = 8'h00;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R11 unused code status", stat_q, 8'h40);
    chk("R11 unused code result", res_a, 8'h00);
    @(negedge clk);
    chk("R11 idle hold", stat_q, 8'h40);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_arith(0, 8'h7F, 8'h01, 8'h38);
    t_arith(0, 8'hFF, 8'h01, 8'h00);
    t_arith(1, 8'h12, 8'h34, 8'h80);
    t_arith(1, 8'h80, 8'h80, 8'h00);
    t_arith(2, 8'h00, 8'h01, 8'h00);
    t_arith(2, 8'h80, 8'h01, 8'h00);
    t_arith(2, 8'h10, 8'h05, 8'h80);
    t_mul(8'h10, 8'h10);
    t_mul(8'h0C, 8'h0A);
    t_div(8'hFB, 8'h12);
    t_div(8'h33, 8'h00);
    t_da(8'h9B, 8'h04);
    t_da(8'h15, 8'h40);
    t_da(8'h22, 8'h80);
    t_rot(1'b0, 8'h81, 8'h44);
    t_rot(1'b1, 8'h81, 8'h00);
    t_rot(1'b1, 8'h00, 8'h80);
    t_cmp(8'h05, 8'h80, 8'h44);
    t_cmp(8'h80, 8'h05, 8'h80);
    t_cmp(8'h42, 8'h42, 8'h80);
    t_psw_writes();
    t_priority();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule